// File: doc/BRIEF.md
# Floating-Point Status and Trap Controller

This block holds the status and control word of a floating-point unit. At the end of every arithmetic operation the unit reports five IEEE exception indications (invalid, divide-by-zero, overflow, underflow, inexact). The controller turns them into per-operation cause bits and accumulated sticky flags. When a cause bit meets its enable bit, it issues a trap request with a fixed exception code. Operations that only approximate their result can ask for inexact to be forced when nothing else was reported.

Software replaces the whole word through a write port. Only the defined bits are kept. The controller decodes two controls from the word and drives them to the arithmetic units: a truncating rounding select and a flush-to-zero select for denormals. A register write and an operation completion can arrive in the same cycle. In that case the write wins and the operation's indications are dropped.

Top module: `fpstat_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0 and no trap is requested.
- R2: A write stores `wr_data & 32'h0005_FFFF`. Bit 17 and bits 31:19 always read 0.
- R3: Field layout is rounding mode [1:0], flags [6:2], enables [11:7], cause [16:12] and denormal mode [18]. Inside each 5-bit field, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid; `exc_flags` uses the same order. Each operation completion replaces the cause field with the operation's indications, so an operation that reports nothing leaves the cause field at 0.
- R4: On an operation completion, the new cause bits are ORed into the flags. Flags are cleared only by a write.
- R5: When the new cause field ANDed with the enable field is nonzero, `trap_req` is high for exactly the cycle in which the new cause is visible, and `trap_code` reads 12'h120 while it is high.
- R6: No trap is requested when the new cause and the enables do not overlap, or in any cycle without an operation completion.
- R7: An operation flagged approximate that reports no indication gets its inexact cause bit forced on. If any other indication is reported, inexact is not forced.
- R8: When a write and an operation completion occur in the same cycle, the word takes the masked write value and no trap is raised.
- R9: `rnd_to_zero` is high exactly when the rounding-mode field holds 2'b01. Every other code means round-to-nearest-even.
- R10: `flush_denorm` follows bit 18 of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write the whole status word |
| wr_data | input | 32 | Value to write |
| op_done | input | 1 | An arithmetic operation completes this cycle |
| op_approx | input | 1 | The completing operation is approximate |
| exc_flags | input | 5 | Exception indications of the completing operation |
| csr_q | output | 32 | Current status word |
| rnd_to_zero | output | 1 | Truncating rounding selected |
| flush_denorm | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | Single-cycle trap request |
| trap_code | output | 12 | Exception code, 12'h120 while a trap is requested |

## Verification
The status word, cause, flags and the trap pulse are each one register stage behind their stimulus. Stimulus applied before a rising edge therefore shows its result just after that same edge. The rounding and flush controls are combinational from the stored word, so they change in that same cycle. The driver applies every stimulus on a falling edge and queues the expected word, trap, code and controls. The monitor compares one queued item 1 ns after each following rising edge. This also catches a trap that lasts too long or arrives late, because idle cycles queue an expectation of no trap.

// File: rtl/fpstat_pkg.sv
// Package: shared constants for the floating-point status controller.
// Assumes a 32-bit status word with fixed field positions.
package fpstat_pkg;
    localparam int CSR_W      = 32;
    localparam int EXC_N      = 5;
    localparam int RM_LSB     = 0;
    localparam int RM_W       = 2;
    localparam int FLG_LSB    = 2;
    localparam int ENA_LSB    = 7;
    localparam int CAU_LSB    = 12;
    localparam int DNM_BIT    = 18;
    localparam int INEXACT_IX = 0;
    localparam int CODE_W     = 12;
    localparam logic [CSR_W-1:0]  WR_MASK   = 32'h0005_FFFF;
    localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;
    localparam logic [RM_W-1:0]   RM_TRUNC  = 2'b01;
endpackage

// File: rtl/fpstat_cause_gen.sv
// Module: builds the cause vector of one completing operation.
// Copies each indication and forces inexact on an approximate operation
// that reported nothing. Purely combinational.
module fpstat_cause_gen #(
    parameter int EXC_N      = fpstat_pkg::EXC_N,
    parameter int INEXACT_IX = fpstat_pkg::INEXACT_IX
) (
    input  logic [EXC_N-1:0] exc_in,
    input  logic             approx,
    output logic [EXC_N-1:0] cause
);
    logic none_seen;

    // Purpose: detect an operation that reported no indication.
    always_comb none_seen = (exc_in == '0);

    for (genvar i = 0; i < EXC_N; i++) begin : g_bit
        if (i == INEXACT_IX) begin : g_inx
            // Purpose: inexact may be forced by an approximate operation.
            always_comb cause[i] = exc_in[i] | (approx & none_seen);
        end else begin : g_pass
            // Purpose: other indications pass straight through.
            always_comb cause[i] = exc_in[i];
        end
    end
endmodule

// File: rtl/fpstat_mode_dec.sv
// Module: decodes the rounding and denormal controls from the stored word.
// Assumes that only one rounding code selects truncation.
module fpstat_mode_dec #(
    parameter int              CSR_W    = fpstat_pkg::CSR_W,
    parameter int              RM_LSB   = fpstat_pkg::RM_LSB,
    parameter int              RM_W     = fpstat_pkg::RM_W,
    parameter int              DNM_BIT  = fpstat_pkg::DNM_BIT,
    parameter logic [RM_W-1:0] RM_TRUNC = fpstat_pkg::RM_TRUNC
) (
    input  logic [CSR_W-1:0] csr,
    output logic             rnd_to_zero,
    output logic             flush_denorm
);
    // Purpose: the truncating code selects round-to-zero; any other code selects nearest-even.
    always_comb rnd_to_zero = (csr[RM_LSB +: RM_W] == RM_TRUNC);
    // Purpose: the denormal bit drives flush-to-zero.
    always_comb flush_denorm = csr[DNM_BIT];
endmodule

// File: rtl/fpstat_state.sv
// Module: holds the status word and the trap pulse.
// A write has priority over an operation completion. A completion
// replaces the cause field, ORs the cause into the flags and pulses
// a trap when the cause meets the enables.
module fpstat_state #(
    parameter int               CSR_W   = fpstat_pkg::CSR_W,
    parameter int               EXC_N   = fpstat_pkg::EXC_N,
    parameter int               FLG_LSB = fpstat_pkg::FLG_LSB,
    parameter int               ENA_LSB = fpstat_pkg::ENA_LSB,
    parameter int               CAU_LSB = fpstat_pkg::CAU_LSB,
    parameter logic [CSR_W-1:0] WR_MASK = fpstat_pkg::WR_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             op_done,
    input  logic [EXC_N-1:0] cause_in,
    output logic [CSR_W-1:0] csr,
    output logic             trap
);
    logic [EXC_N-1:0] ena_now;
    logic [EXC_N-1:0] flg_now;
    logic             hit;

    // Purpose: fetch the fields that an operation update reads.
    always_comb begin
        ena_now = csr[ENA_LSB +: EXC_N];
        flg_now = csr[FLG_LSB +: EXC_N];
        hit     = |(cause_in & ena_now);
    end

    // Purpose: update the word and the trap pulse, with the write taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr  <= '0;
            trap <= 1'b0;
        end else if (wr_en) begin
            csr  <= wr_data & WR_MASK;
            trap <= 1'b0;
        end else if (op_done) begin
            csr[CAU_LSB +: EXC_N] <= cause_in;
            csr[FLG_LSB +: EXC_N] <= flg_now | cause_in;
            trap                  <= hit;
        end else begin
            trap <= 1'b0;
        end
    end
endmodule

// File: rtl/fpstat_ctrl.sv
// Module: top of the floating-point status and trap controller.
// Connects the cause builder, the state register and the mode decoder.
// The trap code is a constant and is driven only while a trap is requested.
module fpstat_ctrl #(
    parameter int CSR_W  = fpstat_pkg::CSR_W,
    parameter int EXC_N  = fpstat_pkg::EXC_N,
    parameter int CODE_W = fpstat_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wr_data,
    input  logic              op_done,
    input  logic              op_approx,
    input  logic [EXC_N-1:0]  exc_flags,
    output logic [CSR_W-1:0]  csr_q,
    output logic              rnd_to_zero,
    output logic              flush_denorm,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    logic [EXC_N-1:0] cause_w;

    fpstat_cause_gen #(.EXC_N(EXC_N)) u_cause (
        .exc_in (exc_flags),
        .approx (op_approx),
        .cause  (cause_w)
    );

    fpstat_state #(.CSR_W(CSR_W), .EXC_N(EXC_N)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .op_done  (op_done),
        .cause_in (cause_w),
        .csr      (csr_q),
        .trap     (trap_req)
    );

    fpstat_mode_dec #(.CSR_W(CSR_W)) u_mode (
        .csr          (csr_q),
        .rnd_to_zero  (rnd_to_zero),
        .flush_denorm (flush_denorm)
    );

    // Purpose: drive the fixed exception code while a trap is requested.
    always_comb trap_code = trap_req ? fpstat_pkg::TRAP_CODE : '0;
endmodule

// File: rtl/fpstat_ctrl_chk.sv
// Checker: temporal properties of fpstat_ctrl, attached by bind.
// Assumes the synchronous active-low reset. Properties that use $past
// wait for one clock after reset has been released.
module fpstat_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        op_done,
    input logic        op_approx,
    input logic [4:0]  exc_flags,
    input logic [31:0] csr_q,
    input logic        trap_req,
    input logic [11:0] trap_code
);
    logic past_ok;

    // Purpose: mark that one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q & ~32'h0005_FFFF) == 32'h0);

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en)) |-> (csr_q == ($past(wr_data) & 32'h0005_FFFF) && !trap_req));

    a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(wr_en)) |-> ((csr_q[6:2] & $past(csr_q[6:2])) == $past(csr_q[6:2])));

    a_r3_quiet_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_done && !wr_en && !op_approx && exc_flags == 5'd0)) |-> (csr_q[16:12] == 5'd0));

    a_r6_trap_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && trap_req) |-> $past(op_done && !wr_en));

    a_r5_trap_meets_enable: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ((csr_q[16:12] & csr_q[11:7]) != 5'd0 && trap_code == 12'h120));
endmodule

bind fpstat_ctrl fpstat_ctrl_chk u_fpstat_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .op_done   (op_done),
    .op_approx (op_approx),
    .exc_flags (exc_flags),
    .csr_q     (csr_q),
    .trap_req  (trap_req),
    .trap_code (trap_code)
);

// File: tb/test_fpstat_ctrl.sv
module test_fpstat_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic        op_approx = 1'b0;
    logic [4:0]  exc_flags = '0;
    logic [31:0] csr_q;
    logic        rnd_to_zero, flush_denorm, trap_req;
    logic [11:0] trap_code;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [31:0] csr;
        logic        trap;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] m_csr = '0;

    always #2 clk = ~clk;

    fpstat_ctrl i_fpstat_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .op_approx(op_approx), .exc_flags(exc_flags),
        .csr_q(csr_q), .rnd_to_zero(rnd_to_zero), .flush_denorm(flush_denorm),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    task automatic check_now(input exp_t e);
        logic       exp_rnd;
        logic       exp_ftz;
        logic [11:0] exp_code;
        exp_rnd  = (e.csr[1:0] == 2'b01);
        exp_ftz  = e.csr[18];
        exp_code = e.trap ? 12'h120 : 12'h000;
        checks++;
        if (csr_q !== e.csr || trap_req !== e.trap || rnd_to_zero !== exp_rnd
            || flush_denorm !== exp_ftz || trap_code !== exp_code) begin
            errors++;
            $display("FAIL %s: csr=%h trap=%b rnd=%b ftz=%b code=%h expected csr=%h trap=%b rnd=%b ftz=%b code=%h",
                     e.tag, csr_q, trap_req, rnd_to_zero, flush_denorm, trap_code,
                     e.csr, e.trap, exp_rnd, exp_ftz, exp_code);
        end
    endtask

    // Drive one cycle of stimulus and queue the outcome the requirements predict.
    task automatic drive(input logic w, input logic [31:0] wd, input logic op,
                         input logic ap, input logic [4:0] ex, input string tag);
        exp_t        e;
        logic [4:0]  c;
        logic        t;
        @(negedge clk);
        wr_en = w; wr_data = wd; op_done = op; op_approx = ap; exc_flags = ex;
        t = 1'b0;
        if (w) begin
            m_csr = wd & 32'h0005_FFFF;            // R2, R8
        end else if (op) begin
            c = ex;
            if (ap && ex == 5'd0) c[0] = 1'b1;     // R7
            m_csr[16:12] = c;                      // R3
            m_csr[6:2]   = m_csr[6:2] | c;         // R4
            t = |(c & m_csr[11:7]);                // R5, R6
        end
        e.csr = m_csr; e.trap = t; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare one queued expectation just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) check_now(sb_q.pop_front());
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        r.csr = '0; r.trap = 1'b0; r.tag = "R1 reset state";
        check_now(r);
        drive(1, 32'hFFFF_FFFF, 0, 0, 5'd0,    "R2 masked write, R10 flush on");
        drive(1, 32'h0000_0001, 0, 0, 5'd0,    "R9 truncating code");
        drive(1, 32'h0000_0002, 0, 0, 5'd0,    "R9 other code is nearest");
        drive(1, 32'h0000_0000, 0, 0, 5'd0,    "R2 clear word");
        drive(0, 32'h0, 1, 0, 5'b10000,        "R3 invalid cause, R6 no enable");
        drive(0, 32'h0, 1, 0, 5'b00100,        "R4 overflow adds to flags");
        drive(0, 32'h0, 1, 0, 5'b00000,        "R3 quiet op clears cause");
        drive(0, 32'h0, 1, 1, 5'b00000,        "R7 approx forces inexact");
        drive(0, 32'h0, 1, 1, 5'b00010,        "R7 other indication wins");
        drive(1, 32'h0000_0400, 0, 0, 5'd0,    "R2 enable divide-by-zero");
        drive(0, 32'h0, 1, 0, 5'b01000,        "R5 trap on enabled cause");
        drive(0, 32'h0, 0, 0, 5'b00000,        "R5 trap lasts one cycle");
        drive(0, 32'h0, 1, 0, 5'b01000,        "R5 back-to-back trap");
        drive(0, 32'h0, 1, 0, 5'b10001,        "R6 disjoint cause no trap");
        drive(0, 32'h0, 1, 1, 5'b00000,        "R6 approx inexact not enabled");
        drive(1, 32'h0004_0001, 1, 0, 5'b01000, "R8 write beats op");
        drive(0, 32'h0, 0, 0, 5'b11111,        "R6 indications without op ignored");
        drive(1, 32'h0000_0F80, 0, 0, 5'd0,    "R2 all enables");
        drive(0, 32'h0, 1, 1, 5'b00000,        "R5 forced inexact traps");
        drive(0, 32'h0, 0, 0, 5'd0,            "R4 flags kept while idle");
        @(negedge clk);
        wr_en = 0; op_done = 0; op_approx = 0; exc_flags = '0;
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule